// File: doc/BRIEF.md
# Ping-Pong Peripheral DMA Channel

This block is a single peripheral DMA channel that owns two buffer slots, A and B, and works through them in alternation. Software writes a buffer start address and a byte length into a slot, then arms the slot through a write-one-to-set alias of the control/status register. While the channel is running, the engine moves data one beat at a time between system memory and one fixed peripheral. On each beat the active slot's start address moves up and its length moves down by the data width. When a slot runs out, the engine disarms it, flags it done and hands over to the other slot. This lets software refill one slot while the other one is draining.

A device address register describes the peripheral side of the transfer: its direction, byte order, burst length, data width, a 4-bit peripheral select and a packed peripheral address. The status register has three aliases: one sets bits, one clears bits and one reads them. An interrupt output asks for service when a slot finishes or an error occurs. The peripheral requests work with a request line. Each request lets the engine run one burst of beats against a memory port that uses a request/acknowledge handshake.

Top module: `dbdma_chan`

## Requirements
- R1: After a synchronous reset the status register reads 0, `irq` is low and `mem_req` is low.
- R2: The word at byte offset 0x00 (device address register) reads back exactly what was written. The start registers (A at 0x10, B at 0x18) read back in full. The length registers (A at 0x14, B at 0x1C) keep only their low 13 bits, so writing 0xFFFF reads back 0x1FFF.
- R3: The status register reads at offset 0x0C with this layout: bit0 run, bit1 interrupt enable, bit2 error, bit3 done A, bit4 armed A, bit5 done B, bit6 armed B, bit7 slot-B-active. Writing ones to offset 0x04 sets bits 0, 1, 4 and 6; ones written there in bits 2, 3, 5 and 7 have no effect. Writing ones to offset 0x08 clears the matching bits 0 to 6. Bit 7 is never written by software.
- R4: Each beat on the active slot advances its start by 1 byte (8-bit width, device address register bit3 = 0) or by 2 bytes (16-bit, bit3 = 1). Each beat lowers the length by the same amount, saturating at 0. When the length reaches 0, the slot's armed bit clears, its done bit sets and bit 7 toggles.
- R5: With both slots armed, every beat of A is issued before any beat of B. Bit 7 reads 1 while B is the active slot. Software may re-arm a finished slot while the other slot is working, and that slot runs next.
- R6: If the active slot is not armed but the other slot is, the channel switches to the other slot and drains it.
- R7: Device address register bit0 selects the direction. With 0, memory is read and the data appears on `per_wdata` with a one-cycle `per_ack` pulse. With 1, `per_rdata` is written to memory (`mem_we` high). Every completed memory beat produces one `per_ack` pulse.
- R8: In 8-bit mode the moved data is zero-extended from its low byte. In 16-bit mode with bit1 = 1 (big-endian) the two bytes are swapped. With bit1 = 0 they pass unchanged.
- R9: A cycle with `per_req` high lets the channel run one burst without looking at `per_req` again. A burst is 4 beats when bit2 = 0 and 8 beats when bit2 = 1, and it is cut short when the slot ends.
- R10: `irq` is high one cycle after interrupt enable is set together with any of error, done A or done B, and low otherwise.
- R11: Clearing run stops new beats; a beat already on the bus completes. Start and length are kept while stopped. Setting run again continues from the same point.
- R12: If the active slot's first beat would use a start address that is not 4-byte aligned, or a 16-bit beat would use an odd address, the channel sets error, clears run and issues no memory access.
- R13: `per_sel` equals device address register bits [7:4]. `per_addr` carries register bits [31:28] at address bits [31:28] and register bits [27:8] at address bits [21:2], with all other bits 0.
- R14: An armed slot whose length is 0 finishes at once, as in R4, without any memory access.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_we | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe; data valid the next cycle |
| reg_addr | input | 5 | Byte offset inside the 32-byte window |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Registered read data |
| mem_req | output | 1 | Memory beat request, held until acknowledged |
| mem_we | output | 1 | Memory beat is a write |
| mem_wide | output | 1 | Memory beat is 16 bits wide |
| mem_addr | output | ADDR_W | Memory byte address of the beat |
| mem_wdata | output | 16 | Memory write data |
| mem_rdata | input | 16 | Memory read data, valid with `mem_ack` |
| mem_ack | input | 1 | Memory beat acknowledge |
| per_req | input | 1 | Peripheral asks for one burst |
| per_ack | output | 1 | One-cycle pulse per transferred beat |
| per_sel | output | 4 | Selected peripheral |
| per_addr | output | 32 | Unpacked peripheral address |
| per_wdata | output | 16 | Data toward the peripheral |
| per_rdata | input | 16 | Data from the peripheral |
| irq | output | 1 | Interrupt request |

## Verification
Most wrong internal states reach the ports within one beat, about three cycles. A slot pointer that does not toggle shows up as a memory address from the wrong buffer. A stale start register repeats an address. A wrong length shows as a beat count that differs from the rounded-up length over width. A lost armed or done bit shows in the next status read and, one cycle later, on `irq`. Bad burst counting shows as a number of beats per `per_req` pulse other than 4 or 8. A broken pause shows as memory activity, or a length register that keeps changing, while run is clear.

// File: rtl/dbdma_pkg.sv
package dbdma_pkg;

  localparam int DATA_W      = 16;
  localparam int BURST_SHORT = 4;
  localparam int BURST_LONG  = 8;

  // word index inside the register window (byte offset / 4)
  localparam logic [2:0] W_DAR    = 3'd0;
  localparam logic [2:0] W_SET    = 3'd1;
  localparam logic [2:0] W_CLR    = 3'd2;
  localparam logic [2:0] W_STAT   = 3'd3;
  localparam logic [2:0] W_A_BASE = 3'd4;
  localparam logic [2:0] W_A_LEN  = 3'd5;
  localparam logic [2:0] W_B_BASE = 3'd6;
  localparam logic [2:0] W_B_LEN  = 3'd7;

  // status bit positions
  localparam int B_RUN    = 0;
  localparam int B_IE     = 1;
  localparam int B_ERR    = 2;
  localparam int B_DONE_A = 3;
  localparam int B_STRT_A = 4;
  localparam int B_DONE_B = 5;
  localparam int B_STRT_B = 6;
  localparam int B_BIU    = 7;

  typedef struct packed {
    logic wide;
    logic burst8;
    logic big;
    logic to_mem;
  } xcfg_t;

  function automatic int strt_pos(input int s);
    return (s == 0) ? B_STRT_A : B_STRT_B;
  endfunction

  function automatic int done_pos(input int s);
    return (s == 0) ? B_DONE_A : B_DONE_B;
  endfunction

  // byte-lane handling for one beat
  function automatic logic [DATA_W-1:0] lane_map(input logic [DATA_W-1:0] d,
                                                  input xcfg_t c);
    if (!c.wide)     return {8'h00, d[7:0]};
    else if (c.big)  return {d[7:0], d[15:8]};
    else             return d;
  endfunction

endpackage

// File: rtl/dbdma_pmap.sv
module dbdma_pmap
  import dbdma_pkg::*;
(
  input  logic [31:0] dar,
  output xcfg_t       cfg,
  output logic [3:0]  per_sel,
  output logic [31:0] per_addr
);

  assign cfg.to_mem = dar[0];
  assign cfg.big    = dar[1];
  assign cfg.burst8 = dar[2];
  assign cfg.wide   = dar[3];
  assign per_sel    = dar[7:4];
  // top nibble stays put, word address field moves down by six bits
  assign per_addr   = {dar[31:28], 6'b000000, dar[27:8], 2'b00};

endmodule

// File: rtl/dbdma_regs.sv
module dbdma_regs
  import dbdma_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int CNT_W  = 13
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              reg_we,
  input  logic              reg_rd,
  input  logic [4:0]        reg_addr,
  input  logic [31:0]       reg_wdata,
  output logic [31:0]       reg_rdata,
  input  logic              ev_adv,
  input  logic              ev_fin,
  input  logic              ev_swap,
  input  logic              ev_err,
  input  logic [1:0]        step,
  output logic [31:0]       dar,
  output logic [7:0]        stat,
  output logic [1:0]        strt,
  output logic              run,
  output logic              biu,
  output logic [ADDR_W-1:0] act_base,
  output logic [CNT_W-1:0]  act_len,
  output logic              act_fresh,
  output logic              irq
);

  localparam int NSLOT = 2;

  logic [2:0] widx;
  logic       unused_lo;
  logic       wr_set, wr_clr;

  logic              run_q, ie_q, err_q, biu_q, irq_q;
  logic [31:0]       dar_q, rdata_q;
  logic [NSLOT-1:0][ADDR_W-1:0] base_v;
  logic [NSLOT-1:0][CNT_W-1:0]  len_v;
  logic [NSLOT-1:0]             fresh_v, strt_v, done_v;

  assign widx      = reg_addr[4:2];
  assign unused_lo = ^reg_addr[1:0];
  assign wr_set    = reg_we && (widx == W_SET);
  assign wr_clr    = reg_we && (widx == W_CLR);

  for (genvar s = 0; s < NSLOT; s++) begin : g_slot
    logic [ADDR_W-1:0] base_q;
    logic [CNT_W-1:0]  len_q;
    logic              fresh_q, strt_q, done_q;
    logic              is_act, wr_base, wr_len;

    assign is_act  = (biu_q == 1'(s));
    assign wr_base = reg_we && (widx == ((s == 0) ? W_A_BASE : W_B_BASE));
    assign wr_len  = reg_we && (widx == ((s == 0) ? W_A_LEN  : W_B_LEN));

    always_ff @(posedge clk) begin
      if (rst) begin
        base_q  <= '0;
        len_q   <= '0;
        fresh_q <= 1'b0;
        strt_q  <= 1'b0;
        done_q  <= 1'b0;
      end else begin
        if (is_act && ev_adv) begin
          base_q  <= base_q + ADDR_W'(step);
          len_q   <= (len_q <= CNT_W'(step)) ? '0 : len_q - CNT_W'(step);
          fresh_q <= 1'b0;
        end
        if (is_act && ev_fin) begin
          strt_q <= 1'b0;
          done_q <= 1'b1;
        end
        if (wr_base) begin
          base_q  <= reg_wdata[ADDR_W-1:0];
          fresh_q <= 1'b1;
        end
        if (wr_len)
          len_q <= reg_wdata[CNT_W-1:0];
        if (wr_set && reg_wdata[strt_pos(s)])
          strt_q <= 1'b1;
        if (wr_clr && reg_wdata[strt_pos(s)])
          strt_q <= 1'b0;
        if (wr_clr && reg_wdata[done_pos(s)])
          done_q <= 1'b0;
      end
    end

    assign base_v[s]  = base_q;
    assign len_v[s]   = len_q;
    assign fresh_v[s] = fresh_q;
    assign strt_v[s]  = strt_q;
    assign done_v[s]  = done_q;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      run_q <= 1'b0;
      ie_q  <= 1'b0;
      err_q <= 1'b0;
      biu_q <= 1'b0;
      dar_q <= '0;
    end else begin
      if (ev_err) begin
        err_q <= 1'b1;
        run_q <= 1'b0;
      end
      if (ev_fin || ev_swap)
        biu_q <= ~biu_q;
      if (reg_we && (widx == W_DAR))
        dar_q <= reg_wdata;
      if (wr_set) begin
        if (reg_wdata[B_RUN]) run_q <= 1'b1;
        if (reg_wdata[B_IE])  ie_q  <= 1'b1;
      end
      if (wr_clr) begin
        if (reg_wdata[B_RUN]) run_q <= 1'b0;
        if (reg_wdata[B_IE])  ie_q  <= 1'b0;
        if (reg_wdata[B_ERR]) err_q <= 1'b0;
      end
    end
  end

  always_comb begin
    stat          = '0;
    stat[B_RUN]   = run_q;
    stat[B_IE]    = ie_q;
    stat[B_ERR]   = err_q;
    stat[B_DONE_A]= done_v[0];
    stat[B_STRT_A]= strt_v[0];
    stat[B_DONE_B]= done_v[1];
    stat[B_STRT_B]= strt_v[1];
    stat[B_BIU]   = biu_q;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rdata_q <= '0;
      irq_q   <= 1'b0;
    end else begin
      irq_q <= ie_q && (err_q || done_v[0] || done_v[1]);
      if (reg_rd) begin
        case (widx)
          W_DAR:    rdata_q <= dar_q;
          W_STAT:   rdata_q <= {24'h0, stat};
          W_A_BASE: rdata_q <= 32'(base_v[0]);
          W_A_LEN:  rdata_q <= 32'(len_v[0]);
          W_B_BASE: rdata_q <= 32'(base_v[1]);
          W_B_LEN:  rdata_q <= 32'(len_v[1]);
          default:  rdata_q <= '0;
        endcase
      end
    end
  end

  assign reg_rdata = rdata_q;
  assign irq       = irq_q;
  assign dar       = dar_q;
  assign strt      = strt_v;
  assign run       = run_q;
  assign biu       = biu_q;
  assign act_base  = biu_q ? base_v[1]  : base_v[0];
  assign act_len   = biu_q ? len_v[1]   : len_v[0];
  assign act_fresh = biu_q ? fresh_v[1] : fresh_v[0];

endmodule

// File: rtl/dbdma_engine.sv
module dbdma_engine
  import dbdma_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int CNT_W  = 13
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              run,
  input  logic              biu,
  input  logic [1:0]        strt,
  input  xcfg_t             cfg,
  input  logic [ADDR_W-1:0] act_base,
  input  logic [CNT_W-1:0]  act_len,
  input  logic              act_fresh,
  input  logic              per_req,
  input  logic              mem_ack,
  input  logic [DATA_W-1:0] mem_rdata,
  input  logic [DATA_W-1:0] per_rdata,
  output logic              ev_adv,
  output logic              ev_fin,
  output logic              ev_swap,
  output logic              ev_err,
  output logic [1:0]        step,
  output logic              mem_req,
  output logic              mem_we,
  output logic              mem_wide,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [DATA_W-1:0] mem_wdata,
  output logic              per_ack,
  output logic [DATA_W-1:0] per_wdata
);

  localparam int BL_W = $clog2(BURST_LONG);

  typedef enum logic {EN_IDLE, EN_BUS} en_state_t;

  en_state_t       state;
  logic [BL_W-1:0] burst_left;
  logic            act_armed, peer_armed, misaligned, final_beat, grant, go;

  always_comb begin
    step       = cfg.wide ? 2'd2 : 2'd1;
    act_armed  = strt[biu];
    peer_armed = strt[~biu];
    misaligned = (act_fresh && (act_base[1:0] != 2'b00)) ||
                 (cfg.wide && act_base[0]);
    final_beat = (act_len <= CNT_W'(step));
    grant      = (burst_left != '0) || per_req;
    ev_adv     = 1'b0;
    ev_fin     = 1'b0;
    ev_swap    = 1'b0;
    ev_err     = 1'b0;
    go         = 1'b0;
    case (state)
      EN_IDLE: begin
        if (run) begin
          if (act_armed) begin
            if (act_len == '0)   ev_fin = 1'b1;
            else if (misaligned) ev_err = 1'b1;
            else if (grant)      go     = 1'b1;
          end else if (peer_armed) begin
            ev_swap = 1'b1;
          end
        end
      end
      EN_BUS: begin
        if (mem_ack) begin
          ev_adv = 1'b1;
          ev_fin = final_beat;
        end
      end
      default: ;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state      <= EN_IDLE;
      burst_left <= '0;
      mem_req    <= 1'b0;
      mem_we     <= 1'b0;
      mem_wide   <= 1'b0;
      mem_addr   <= '0;
      mem_wdata  <= '0;
      per_ack    <= 1'b0;
      per_wdata  <= '0;
    end else begin
      per_ack <= 1'b0;
      case (state)
        EN_IDLE: begin
          if (go) begin
            state     <= EN_BUS;
            mem_req   <= 1'b1;
            mem_we    <= cfg.to_mem;
            mem_wide  <= cfg.wide;
            mem_addr  <= act_base;
            mem_wdata <= lane_map(per_rdata, cfg);
            burst_left <= (burst_left != '0) ? burst_left - 1'b1 :
                          BL_W'(cfg.burst8 ? BURST_LONG - 1 : BURST_SHORT - 1);
          end
          if (ev_fin)
            burst_left <= '0;
        end
        EN_BUS: begin
          if (mem_ack) begin
            state   <= EN_IDLE;
            mem_req <= 1'b0;
            per_ack <= 1'b1;
            if (!cfg.to_mem)
              per_wdata <= lane_map(mem_rdata, cfg);
            if (final_beat)
              burst_left <= '0;
          end
        end
        default: state <= EN_IDLE;
      endcase
    end
  end

endmodule

// File: rtl/dbdma_chan.sv
module dbdma_chan
  import dbdma_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int CNT_W  = 13
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              reg_we,
  input  logic              reg_rd,
  input  logic [4:0]        reg_addr,
  input  logic [31:0]       reg_wdata,
  output logic [31:0]       reg_rdata,
  output logic              mem_req,
  output logic              mem_we,
  output logic              mem_wide,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [15:0]       mem_wdata,
  input  logic [15:0]       mem_rdata,
  input  logic              mem_ack,
  input  logic              per_req,
  output logic              per_ack,
  output logic [3:0]        per_sel,
  output logic [31:0]       per_addr,
  output logic [15:0]       per_wdata,
  input  logic [15:0]       per_rdata,
  output logic              irq
);

  logic              ev_adv, ev_fin, ev_swap, ev_err;
  logic [1:0]        step;
  logic [31:0]       dar;
  logic [7:0]        stat;
  logic [1:0]        strt;
  logic              run, biu, act_fresh;
  logic [ADDR_W-1:0] act_base;
  logic [CNT_W-1:0]  act_len;
  xcfg_t             cfg;

  dbdma_regs #(.ADDR_W(ADDR_W), .CNT_W(CNT_W)) u_regs (
    .clk(clk), .rst(rst),
    .reg_we(reg_we), .reg_rd(reg_rd), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .ev_adv(ev_adv), .ev_fin(ev_fin), .ev_swap(ev_swap), .ev_err(ev_err),
    .step(step), .dar(dar), .stat(stat), .strt(strt), .run(run), .biu(biu),
    .act_base(act_base), .act_len(act_len), .act_fresh(act_fresh), .irq(irq)
  );

  dbdma_pmap u_pmap (
    .dar(dar), .cfg(cfg), .per_sel(per_sel), .per_addr(per_addr)
  );

  dbdma_engine #(.ADDR_W(ADDR_W), .CNT_W(CNT_W)) u_eng (
    .clk(clk), .rst(rst),
    .run(run), .biu(biu), .strt(strt), .cfg(cfg),
    .act_base(act_base), .act_len(act_len), .act_fresh(act_fresh),
    .per_req(per_req), .mem_ack(mem_ack), .mem_rdata(mem_rdata),
    .per_rdata(per_rdata),
    .ev_adv(ev_adv), .ev_fin(ev_fin), .ev_swap(ev_swap), .ev_err(ev_err),
    .step(step),
    .mem_req(mem_req), .mem_we(mem_we), .mem_wide(mem_wide),
    .mem_addr(mem_addr), .mem_wdata(mem_wdata),
    .per_ack(per_ack), .per_wdata(per_wdata)
  );

endmodule

// File: rtl/dbdma_chk.sv
module dbdma_chk #(
  parameter int ADDR_W = 32
) (
  input logic              clk,
  input logic              rst,
  input logic              mem_req,
  input logic              mem_ack,
  input logic              mem_wide,
  input logic [ADDR_W-1:0] mem_addr,
  input logic              per_ack,
  input logic              irq,
  input logic [7:0]        stat
);

  // R4: a pending beat keeps its request and address until acknowledged
  p_req_hold_r4: assert property (@(posedge clk) disable iff (rst)
    (mem_req && !mem_ack) |=> (mem_req && $stable(mem_addr)));

  // R4: finishing slot A leaves it disarmed
  p_done_disarms_r4: assert property (@(posedge clk) disable iff (rst)
    $rose(stat[3]) |-> !stat[4]);

  // R5: once A finishes, B becomes the active slot
  p_hand_over_r5: assert property (@(posedge clk) disable iff (rst)
    $rose(stat[3]) |-> stat[7]);

  // R7: every acknowledged memory beat is reported to the peripheral
  p_beat_to_periph_r7: assert property (@(posedge clk) disable iff (rst)
    (mem_req && mem_ack) |=> per_ack);

  // R10: no interrupt without the enable one cycle earlier
  p_irq_needs_ie_r10: assert property (@(posedge clk) disable iff (rst)
    !$past(stat[1]) |-> !irq);

  // R11: a stopped, idle channel does not start a beat
  p_paused_quiet_r11: assert property (@(posedge clk) disable iff (rst)
    (!stat[0] && !mem_req) |=> !mem_req);

  // R12: an error always leaves run clear
  p_err_stops_r12: assert property (@(posedge clk) disable iff (rst)
    $rose(stat[2]) |-> !stat[0]);

  // R12: 16-bit beats never use an odd address
  p_wide_even_r12: assert property (@(posedge clk) disable iff (rst)
    (mem_req && mem_wide) |-> !mem_addr[0]);

endmodule

bind dbdma_chan dbdma_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk(clk), .rst(rst), .mem_req(mem_req), .mem_ack(mem_ack),
  .mem_wide(mem_wide), .mem_addr(mem_addr), .per_ack(per_ack),
  .irq(irq), .stat(stat)
);

// File: tb/tb_dbdma_chan.sv
module tb_dbdma_chan;

  localparam logic [15:0] PERD = 16'hB27E;

  logic        clk = 1'b0;
  logic        rst;
  logic        reg_we, reg_rd;
  logic [4:0]  reg_addr;
  logic [31:0] reg_wdata, reg_rdata;
  logic        mem_req, mem_we, mem_wide, mem_ack;
  logic [31:0] mem_addr;
  logic [15:0] mem_wdata, mem_rdata;
  logic        per_req, per_ack;
  logic [3:0]  per_sel;
  logic [31:0] per_addr;
  logic [15:0] per_wdata, per_rdata;
  logic        irq;

  int checks = 0;
  int errors = 0;

  always #5 clk = ~clk;

  dbdma_chan dut (
    .clk(clk), .rst(rst), .reg_we(reg_we), .reg_rd(reg_rd),
    .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .mem_req(mem_req), .mem_we(mem_we), .mem_wide(mem_wide),
    .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_rdata(mem_rdata),
    .mem_ack(mem_ack), .per_req(per_req), .per_ack(per_ack),
    .per_sel(per_sel), .per_addr(per_addr), .per_wdata(per_wdata),
    .per_rdata(per_rdata), .irq(irq)
  );

  function automatic logic [15:0] memf(input logic [31:0] a);
    return a[15:0] ^ 16'h5A3C;
  endfunction

  function automatic logic [15:0] lanes(input logic [15:0] d, input logic wide,
                                        input logic big);
    if (!wide) return {8'h00, d[7:0]};
    if (big)   return {d[7:0], d[15:8]};
    return d;
  endfunction

  // memory model: one-cycle acknowledge
  always @(posedge clk) begin
    if (rst) mem_ack <= 1'b0;
    else begin
      mem_ack   <= mem_req && !mem_ack;
      mem_rdata <= memf(mem_addr);
    end
  end

  // beat logs
  logic        clr_log = 1'b0;
  int          nb = 0, np = 0;
  logic [31:0] la [64];
  logic        lw [64];
  logic [15:0] ld [64];
  logic [15:0] lp [64];
  always @(posedge clk) begin
    if (clr_log) begin
      nb <= 0;
      np <= 0;
    end else begin
      if (mem_req && mem_ack && nb < 64) begin
        la[nb] <= mem_addr; lw[nb] <= mem_we; ld[nb] <= mem_wdata; nb <= nb + 1;
      end
      if (per_ack && np < 64) begin
        lp[np] <= per_wdata; np <= np + 1;
      end
    end
  end

  task automatic chk(input string what, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", what, act, exp);
    end
  endtask

  task automatic wr(input logic [4:0] a, input logic [31:0] d);
    @(negedge clk); reg_we = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk); reg_we = 1'b0;
  endtask

  task automatic rd(input logic [4:0] a, output logic [31:0] d);
    @(negedge clk); reg_rd = 1'b1; reg_addr = a;
    @(negedge clk); reg_rd = 1'b0; d = reg_rdata;
  endtask

  task automatic do_reset();
    @(negedge clk); rst = 1'b1; clr_log = 1'b1; per_req = 1'b0;
    repeat (3) @(negedge clk);
    rst = 1'b0; clr_log = 1'b0;
  endtask

  task automatic pulse_req();
    @(negedge clk); per_req = 1'b1;
    @(negedge clk); per_req = 1'b0;
    repeat (40) @(negedge clk);
  endtask

  task automatic wait_stat(input logic [7:0] mask);
    logic [31:0] s;
    bit hit = 0;
    for (int i = 0; i < 300 && !hit; i++) begin
      rd(5'h0C, s);
      if ((s[7:0] & mask) == mask) hit = 1;
    end
    repeat (4) @(negedge clk);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: run did not finish actual=hung expected=done");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    logic [31:0] s, c1, ex;
    int n1;
    reg_we = 0; reg_rd = 0; reg_addr = 0; reg_wdata = 0;
    per_req = 0; per_rdata = PERD; rst = 1'b1;

    // R1 reset state
    do_reset();
    rd(5'h0C, s);
    chk("R1 status after reset", s, 32'h0);
    chk("R1 irq after reset", 32'(irq), 32'h0);
    chk("R1 mem_req after reset", 32'(mem_req), 32'h0);

    // R2 readback, R13 address unpack
    wr(5'h00, 32'hA5F3C7B6);
    rd(5'h00, s);
    chk("R2 device register readback", s, 32'hA5F3C7B6);
    chk("R13 per_sel", 32'(per_sel), 32'hB);
    ex = {4'hA, 6'b0, 20'h5F3C7, 2'b00};
    chk("R13 per_addr", per_addr, ex);
    wr(5'h14, 32'h0000FFFF);
    rd(5'h14, s);
    chk("R2 length masked to 13 bits", s, 32'h1FFF);
    wr(5'h18, 32'h12345678);
    rd(5'h18, s);
    chk("R2 slot B start readback", s, 32'h12345678);

    // R3 aliases
    wr(5'h04, 32'hAC);
    rd(5'h0C, s);
    chk("R3 set alias ignores bits 2,3,5,7", s, 32'h0);
    wr(5'h04, 32'h03);
    rd(5'h0C, s);
    chk("R3 set alias run/ie", s, 32'h03);
    wr(5'h08, 32'h01);
    rd(5'h0C, s);
    chk("R3 clear alias run", s, 32'h02);
    chk("R10 irq low with no flags", 32'(irq), 32'h0);

    // sweep: direction x endian x burst x width (R4 R5 R7 R8 R13)
    for (int k = 0; k < 16; k++) begin
      logic dir, big, wide;
      int w, ca, cb, na, nbb;
      logic [31:0] sa, sb;
      dir = k[0]; big = k[1]; wide = k[3];
      w = wide ? 2 : 1;
      ca = 5 + k % 3; cb = 3 + k % 4;
      na = (ca + w - 1) / w; nbb = (cb + w - 1) / w;
      sa = 32'h1000 + 32'(k * 64); sb = 32'h8000 + 32'(k * 64);
      do_reset();
      per_req = 1'b1;
      wr(5'h00, 32'(k) | (32'(k) << 4));
      chk("R13 per_sel in sweep", 32'(per_sel), 32'(k));
      wr(5'h10, sa); wr(5'h14, 32'(ca));
      wr(5'h18, sb); wr(5'h1C, 32'(cb));
      wr(5'h04, 32'h53);
      wait_stat(8'h28);
      chk("R5 total beats both slots", 32'(nb), 32'(na + nbb));
      chk("R7 one per_ack per beat", 32'(np), 32'(na + nbb));
      for (int i = 0; i < na + nbb && i < 64; i++) begin
        ex = (i < na) ? sa + 32'(i * w) : sb + 32'((i - na) * w);
        chk("R4 R5 beat address order", la[i], ex);
        chk("R7 beat direction", 32'(lw[i]), 32'(dir));
        if (dir) chk("R7 R8 memory write data", 32'(ld[i]), 32'(lanes(PERD, wide, big)));
        else     chk("R7 R8 peripheral data", 32'(lp[i]), 32'(lanes(memf(ex), wide, big)));
      end
      rd(5'h0C, s);
      chk("R4 R5 status after both slots", s, 32'h2B);
      chk("R10 irq after done", 32'(irq), 32'h1);
      per_req = 1'b0;
    end

    // R9 burst lengths
    do_reset();
    wr(5'h00, 32'h0); wr(5'h10, 32'h200); wr(5'h14, 32'd10);
    wr(5'h04, 32'h13);
    pulse_req();
    chk("R9 burst of 4", 32'(nb), 32'd4);
    pulse_req();
    chk("R9 second burst of 4", 32'(nb), 32'd8);
    pulse_req();
    chk("R9 burst cut at slot end", 32'(nb), 32'd10);
    rd(5'h0C, s);
    chk("R4 status after slot A", s, 32'h8B);
    wr(5'h00, 32'h4); wr(5'h10, 32'h300); wr(5'h14, 32'd20);
    wr(5'h04, 32'h10);
    pulse_req();
    chk("R9 burst of 8", 32'(nb), 32'd18);

    // R5 alternation with re-arm
    do_reset();
    wr(5'h00, 32'h0);
    wr(5'h10, 32'h400); wr(5'h14, 32'd4);
    wr(5'h18, 32'h500); wr(5'h1C, 32'd4);
    wr(5'h04, 32'h53);
    pulse_req();
    rd(5'h0C, s);
    chk("R5 B active after A, B armed", s, 32'hCB);
    chk("R10 irq on done A", 32'(irq), 32'h1);
    wr(5'h08, 32'h08); wr(5'h10, 32'h600); wr(5'h14, 32'd4);
    wr(5'h04, 32'h10);
    pulse_req();
    rd(5'h0C, s);
    chk("R5 B done, A re-armed", s, 32'h33);
    pulse_req();
    rd(5'h0C, s);
    chk("R5 re-armed A done", s, 32'hAB);
    chk("R5 B first address", la[4], 32'h500);
    chk("R5 B last address", la[7], 32'h503);
    chk("R5 re-armed A address", la[8], 32'h600);
    chk("R5 beat count", 32'(nb), 32'd12);

    // R6 only B armed while A active
    do_reset();
    per_req = 1'b1;
    wr(5'h18, 32'h700); wr(5'h1C, 32'd3);
    wr(5'h04, 32'h43);
    wait_stat(8'h20);
    chk("R6 beats from B", 32'(nb), 32'd3);
    chk("R6 first address from B", la[0], 32'h700);
    rd(5'h0C, s);
    chk("R6 status after B", s, 32'h23);
    per_req = 1'b0;

    // R11 pause and resume
    do_reset();
    per_req = 1'b1;
    wr(5'h10, 32'h800); wr(5'h14, 32'd40);
    wr(5'h04, 32'h13);
    repeat (20) @(negedge clk);
    wr(5'h08, 32'h01);
    repeat (6) @(negedge clk);
    n1 = nb;
    rd(5'h14, c1);
    repeat (30) @(negedge clk);
    chk("R11 no beats while paused", 32'(nb), 32'(n1));
    rd(5'h14, s);
    chk("R11 length held while paused", s, c1);
    chk("R11 length matches beats", c1, 32'(40 - n1));
    wr(5'h04, 32'h01);
    wait_stat(8'h08);
    chk("R11 all beats after resume", 32'(nb), 32'd40);
    chk("R11 last address", la[39], 32'h800 + 32'd39);
    per_req = 1'b0;

    // R12 misaligned start
    do_reset();
    per_req = 1'b1;
    wr(5'h10, 32'h902); wr(5'h14, 32'd4);
    wr(5'h04, 32'h13);
    repeat (10) @(negedge clk);
    rd(5'h0C, s);
    chk("R12 error set, run cleared", s, 32'h16);
    chk("R12 no memory access", 32'(nb), 32'd0);
    chk("R10 irq on error", 32'(irq), 32'h1);
    per_req = 1'b0;

    // R14 zero length
    do_reset();
    per_req = 1'b1;
    wr(5'h10, 32'hB00); wr(5'h14, 32'd0);
    wr(5'h04, 32'h13);
    repeat (6) @(negedge clk);
    rd(5'h0C, s);
    chk("R14 zero length completes", s, 32'h8B);
    chk("R14 no memory access", 32'(nb), 32'd0);
    wr(5'h08, 32'h08);
    repeat (3) @(negedge clk);
    chk("R10 irq drops after clear", 32'(irq), 32'h0);
    per_req = 1'b0;

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule